// File: doc/BRIEF.md
# Brute-Force Password Candidate Generator

This block feeds a bank of parallel hash workers with candidate passwords for an exhaustive search. Candidates are strings of one up to eight printable characters. In each cycle every worker lane receives its own fresh candidate as a zero-padded 64-bit word together with its length, so that a worker can build its message padding without further decoding. The enumeration is deterministic: all one-character strings first, then all two-character strings, and so on. When a string grows, the new character appears at the front.

A controller pulses `start`. The generator then sweeps the space, with lane k always holding the k-th entry of the current batch. Workers answer with a per-lane match flag a fixed number of cycles after they were handed a candidate. The first qualified match stops the sweep and latches the matching string. If the space runs out and the last in-flight answers have come back without a hit, the block reports exhaustion instead. The lane count, the maximum length and the answer latency are all parameters.

Top module: `pwcand_gen`

## Requirements
- R1: After reset, `busy`, `found`, `exhausted`, every `cand_valid` bit, `hit_word` and `hit_len` are all zero until the first `start` is accepted.
- R2: In a valid lane word, byte j (bits [8j+7:8j]) holds a code from 32 to 126 for every j below the lane length, and zero for every j at or above it.
- R3: Candidate index n is mapped to a string as follows. Indices 0..94 are the one-character strings, the next 95^2 are the two-character strings, and so on. Within a length L, the string is the base-95 number of that rank, with digit value = code - 32. Byte L-1 (the last character) is the least significant digit and byte 0 (the front character) is the most significant, so the front character is the one added when the length grows.
- R4: The first cycle after an accepted `start` presents indices 0..N-1 on lanes 0..N-1 (N = NUM_WORKERS). Each later cycle in the sweep presents the next N indices. Lane k occupies bits [64k+63:64k] of `cand_word` and bits [LEN_W*k+LEN_W-1:LEN_W*k] of `cand_len`. `cand_valid` is zero whenever `busy` is low or the sweep is draining.
- R5: In the last batch, lanes whose index lies beyond the last candidate of length MAX_LEN have `cand_valid` low.
- R6: `match[k]` sampled in cycle c refers to the candidate on lane k in cycle c-MATCH_LATENCY. A qualified match moves the block from busy to `found` at the next edge and latches that candidate's word and length into `hit_word`/`hit_len`. These are held, with `found` high, until the next accepted `start`.
- R7: When several qualified matches arrive in the same cycle, the lowest lane index wins.
- R8: A match flag has no effect when the referenced slot held no valid candidate, or when the block is not busy. After exhaustion `hit_len` and `hit_word` are zero.
- R9: After the last batch the block drains for MATCH_LATENCY cycles and then raises `exhausted`. A qualified match arriving in any drain cycle, including the last one, takes priority and yields `found` instead. At most one of `busy`, `found`, `exhausted` is high.
- R10: `start` is ignored while `busy` is high. Otherwise it restarts the sweep from index 0 and clears `found`, `exhausted`, `hit_word` and `hit_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new sweep (one-cycle pulse) |
| match | input | NUM_WORKERS | Per-lane match answers from the workers |
| cand_word | output | 64*NUM_WORKERS | Per-lane candidate string, zero padded |
| cand_len | output | LEN_W*NUM_WORKERS | Per-lane candidate length in characters |
| cand_valid | output | NUM_WORKERS | Per-lane candidate present |
| busy | output | 1 | Sweep or drain in progress |
| found | output | 1 | A match was latched |
| exhausted | output | 1 | Space swept without a match |
| hit_word | output | 64 | Latched matching string |
| hit_len | output | LEN_W | Latched matching length |

## Verification
The end of the sweep and a match can land on the same edge. This happens when the answer for the very last candidate comes back in the final drain cycle, where exhaustion would otherwise be declared. The bench provokes it by using a worker emulator that targets the final string of the space, and it expects `found` with that string rather than `exhausted`. A second run forces a match onto the invalid slot of the partial last batch in that same cycle, and expects `exhausted` with an empty hit. Two lanes answering in one cycle are also provoked, to judge the lane priority.

// File: rtl/pwcand_pkg.sv
`timescale 1ns/1ps
package pwcand_pkg;
   localparam int SYM_BASE  = 32;
   localparam int SYM_COUNT = 95;
   localparam int DIG_W     = 7;
   localparam int WORD_W    = 64;
   localparam int LEN_LIMIT = 8;

   typedef enum logic [2:0] {
      GEN_IDLE,
      GEN_RUN,
      GEN_DRAIN,
      GEN_FOUND,
      GEN_EXHAUST
   } gen_state_e;
endpackage

// File: rtl/pwcand_lane.sv
`timescale 1ns/1ps
module pwcand_lane
   import pwcand_pkg::*;
#(
   parameter int MAX_LEN  = 8,
   parameter int STEP     = 4,
   parameter int LANE_IDX = 0,
   parameter int LEN_W    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     advance,
   output logic [MAX_LEN*DIG_W-1:0] digits_o,
   output logic [LEN_W-1:0]         len_o,
   output logic                     live_o,
   output logic                     live_nxt_o
);
   localparam logic [DIG_W:0]   STEP_V = (DIG_W+1)'(STEP);
   localparam logic [DIG_W:0]   SYM_V  = (DIG_W+1)'(SYM_COUNT);
   localparam logic [DIG_W-1:0] SEED_V = DIG_W'(LANE_IDX);

   if (LANE_IDX >= STEP) begin : g_bad_idx
      $error("lane index must be below the step");
   end

   logic [DIG_W-1:0] dig_q    [MAX_LEN];
   logic [DIG_W-1:0] step_dig [MAX_LEN];
   logic [LEN_W-1:0] len_q;
   logic             live_q;
   logic             wrap;
   logic             at_top;
   logic             step_live;

   // add STEP to the low digit, ripple the carry through the used digits
   always_comb begin
      logic [DIG_W:0] acc;
      logic           cy;
      acc = '0;
      cy  = 1'b0;
      for (int i = 0; i < MAX_LEN; i++) begin
         step_dig[i] = dig_q[i];
         if (i < int'(len_q)) begin
            acc = {1'b0, dig_q[i]} + ((i == 0) ? STEP_V : {{DIG_W{1'b0}}, cy});
            if (acc >= SYM_V) begin
               step_dig[i] = DIG_W'(acc - SYM_V);
               cy          = 1'b1;
            end else begin
               step_dig[i] = acc[DIG_W-1:0];
               cy          = 1'b0;
            end
         end
      end
      wrap = cy;
   end

   assign at_top     = (len_q == LEN_W'(MAX_LEN));
   assign step_live  = live_q & ~(wrap & at_top);
   assign live_nxt_o = step_live;
   assign live_o     = live_q;
   assign len_o      = len_q;

   always_comb begin
      for (int i = 0; i < MAX_LEN; i++) begin
         digits_o[i*DIG_W +: DIG_W] = dig_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_LEN; i++) dig_q[i] <= '0;
         len_q  <= '0;
         live_q <= 1'b0;
      end else if (load) begin
         for (int i = 1; i < MAX_LEN; i++) dig_q[i] <= '0;
         dig_q[0] <= SEED_V;
         len_q    <= LEN_W'(1);
         live_q   <= 1'b1;
      end else if (advance && live_q) begin
         for (int i = 0; i < MAX_LEN; i++) dig_q[i] <= step_dig[i];
         if (wrap && !at_top) len_q <= len_q + LEN_W'(1);
         live_q <= step_live;
      end
   end
endmodule

// File: rtl/pwcand_fmt.sv
`timescale 1ns/1ps
module pwcand_fmt
   import pwcand_pkg::*;
#(
   parameter int MAX_LEN = 8,
   parameter int LEN_W   = 4
) (
   input  logic [MAX_LEN*DIG_W-1:0] digits_i,
   input  logic [LEN_W-1:0]         len_i,
   output logic [WORD_W-1:0]        word_o
);
   // front character (byte 0) carries the most significant digit
   always_comb begin
      int src;
      word_o = '0;
      src    = 0;
      for (int j = 0; j < MAX_LEN; j++) begin
         if (j < int'(len_i)) begin
            src = int'(len_i) - 1 - j;
            word_o[j*8 +: 8] = 8'(SYM_BASE) + {1'b0, digits_i[src*DIG_W +: DIG_W]};
         end
      end
   end
endmodule

// File: rtl/pwcand_hitq.sv
`timescale 1ns/1ps
module pwcand_hitq
   import pwcand_pkg::*;
#(
   parameter int NUM_WORKERS = 4,
   parameter int DEPTH       = 2,
   parameter int LEN_W       = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [NUM_WORKERS*WORD_W-1:0] words_i,
   input  logic [NUM_WORKERS*LEN_W-1:0]  lens_i,
   input  logic [NUM_WORKERS-1:0]        valids_i,
   input  logic [NUM_WORKERS-1:0]        match_i,
   output logic                          hit_o,
   output logic [WORD_W-1:0]             hit_word_o,
   output logic [LEN_W-1:0]              hit_len_o
);
   logic [NUM_WORKERS*WORD_W-1:0] tap_w;
   logic [NUM_WORKERS*LEN_W-1:0]  tap_l;
   logic [NUM_WORKERS-1:0]        tap_v;

   if (DEPTH == 0) begin : g_direct
      assign tap_w = words_i;
      assign tap_l = lens_i;
      assign tap_v = valids_i;
   end else begin : g_delay
      logic [NUM_WORKERS*WORD_W-1:0] stg_w [DEPTH];
      logic [NUM_WORKERS*LEN_W-1:0]  stg_l [DEPTH];
      logic [NUM_WORKERS-1:0]        stg_v [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
               stg_w[s] <= '0;
               stg_l[s] <= '0;
               stg_v[s] <= '0;
            end
         end else begin
            stg_w[0] <= words_i;
            stg_l[0] <= lens_i;
            stg_v[0] <= flush ? '0 : valids_i;
            for (int s = 1; s < DEPTH; s++) begin
               stg_w[s] <= stg_w[s-1];
               stg_l[s] <= stg_l[s-1];
               stg_v[s] <= flush ? '0 : stg_v[s-1];
            end
         end
      end

      assign tap_w = stg_w[DEPTH-1];
      assign tap_l = stg_l[DEPTH-1];
      assign tap_v = stg_v[DEPTH-1];
   end

   // lowest lane wins: scan downward so the last write is the lowest
   always_comb begin
      hit_o      = 1'b0;
      hit_word_o = '0;
      hit_len_o  = '0;
      for (int k = NUM_WORKERS - 1; k >= 0; k--) begin
         if (match_i[k] && tap_v[k]) begin
            hit_o      = 1'b1;
            hit_word_o = tap_w[k*WORD_W +: WORD_W];
            hit_len_o  = tap_l[k*LEN_W +: LEN_W];
         end
      end
   end
endmodule

// File: rtl/pwcand_gen.sv
`timescale 1ns/1ps
module pwcand_gen
   import pwcand_pkg::*;
#(
   parameter int  NUM_WORKERS   = 4,
   parameter int  MAX_LEN       = 8,
   parameter int  MATCH_LATENCY = 2,
   localparam int LEN_W         = $clog2(MAX_LEN + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NUM_WORKERS-1:0]        match,
   output logic [NUM_WORKERS*WORD_W-1:0] cand_word,
   output logic [NUM_WORKERS*LEN_W-1:0]  cand_len,
   output logic [NUM_WORKERS-1:0]        cand_valid,
   output logic                          busy,
   output logic                          found,
   output logic                          exhausted,
   output logic [WORD_W-1:0]             hit_word,
   output logic [LEN_W-1:0]              hit_len
);
   localparam int DCNT_W = $clog2(MATCH_LATENCY + 2);

   if (NUM_WORKERS < 1 || NUM_WORKERS > SYM_COUNT) begin : g_bad_workers
      $error("NUM_WORKERS must lie in 1..95");
   end
   if (MAX_LEN < 1 || MAX_LEN > LEN_LIMIT) begin : g_bad_len
      $error("MAX_LEN must lie in 1..8");
   end
   if (MATCH_LATENCY < 0) begin : g_bad_lat
      $error("MATCH_LATENCY must not be negative");
   end

   gen_state_e               state_q;
   logic [DCNT_W-1:0]        dcnt_q;
   logic [WORD_W-1:0]        hit_word_q;
   logic [LEN_W-1:0]         hit_len_q;

   logic [MAX_LEN*DIG_W-1:0] lane_dig [NUM_WORKERS];
   logic [LEN_W-1:0]         lane_len [NUM_WORKERS];
   logic [NUM_WORKERS-1:0]   lane_live;
   logic [NUM_WORKERS-1:0]   lane_live_nxt;

   logic                     run_st;
   logic                     accept_start;
   logic                     q_hit;
   logic [WORD_W-1:0]        q_word;
   logic [LEN_W-1:0]         q_len;

   assign run_st       = (state_q == GEN_RUN);
   assign busy         = run_st | (state_q == GEN_DRAIN);
   assign found        = (state_q == GEN_FOUND);
   assign exhausted    = (state_q == GEN_EXHAUST);
   assign accept_start = start & ~busy;
   assign hit_word     = hit_word_q;
   assign hit_len      = hit_len_q;

   for (genvar k = 0; k < NUM_WORKERS; k++) begin : g_lane
      pwcand_lane #(
         .MAX_LEN (MAX_LEN),
         .STEP    (NUM_WORKERS),
         .LANE_IDX(k),
         .LEN_W   (LEN_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (accept_start),
         .advance   (run_st),
         .digits_o  (lane_dig[k]),
         .len_o     (lane_len[k]),
         .live_o    (lane_live[k]),
         .live_nxt_o(lane_live_nxt[k])
      );

      pwcand_fmt #(
         .MAX_LEN(MAX_LEN),
         .LEN_W  (LEN_W)
      ) u_fmt (
         .digits_i(lane_dig[k]),
         .len_i   (lane_len[k]),
         .word_o  (cand_word[k*WORD_W +: WORD_W])
      );

      assign cand_len[k*LEN_W +: LEN_W] = lane_len[k];
      assign cand_valid[k]              = run_st & lane_live[k];
   end

   pwcand_hitq #(
      .NUM_WORKERS(NUM_WORKERS),
      .DEPTH      (MATCH_LATENCY),
      .LEN_W      (LEN_W)
   ) u_hitq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (accept_start),
      .words_i   (cand_word),
      .lens_i    (cand_len),
      .valids_i  (cand_valid),
      .match_i   (match),
      .hit_o     (q_hit),
      .hit_word_o(q_word),
      .hit_len_o (q_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= GEN_IDLE;
         dcnt_q     <= '0;
         hit_word_q <= '0;
         hit_len_q  <= '0;
      end else begin
         unique case (state_q)
            GEN_RUN: begin
               if (q_hit) begin
                  state_q    <= GEN_FOUND;
                  hit_word_q <= q_word;
                  hit_len_q  <= q_len;
               end else if (lane_live_nxt == '0) begin
                  if (MATCH_LATENCY == 0) begin
                     state_q <= GEN_EXHAUST;
                  end else begin
                     state_q <= GEN_DRAIN;
                     dcnt_q  <= DCNT_W'(MATCH_LATENCY);
                  end
               end
            end
            GEN_DRAIN: begin
               if (q_hit) begin
                  state_q    <= GEN_FOUND;
                  hit_word_q <= q_word;
                  hit_len_q  <= q_len;
               end else if (dcnt_q == DCNT_W'(1)) begin
                  state_q <= GEN_EXHAUST;
               end else begin
                  dcnt_q <= dcnt_q - DCNT_W'(1);
               end
            end
            default: begin
               if (start) begin
                  state_q    <= GEN_RUN;
                  hit_word_q <= '0;
                  hit_len_q  <= '0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/pwcand_gen_chk.sv
`timescale 1ns/1ps
module pwcand_gen_chk #(
   parameter int NUM_WORKERS = 4,
   parameter int MAX_LEN     = 8,
   parameter int LEN_W       = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic [NUM_WORKERS*64-1:0]    cand_word,
   input logic [NUM_WORKERS*LEN_W-1:0] cand_len,
   input logic [NUM_WORKERS-1:0]       cand_valid,
   input logic                         busy,
   input logic                         found,
   input logic                         exhausted,
   input logic [63:0]                  hit_word,
   input logic [LEN_W-1:0]             hit_len
);
   assert_valid_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cand_valid == '0));

   assert_one_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, found, exhausted}));

   assert_hit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (found && !start) |=> (found && $stable(hit_word) && $stable(hit_len)));

   assert_exhaust_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> (hit_len == '0 && hit_word == '0));

   assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   for (genvar k = 0; k < NUM_WORKERS; k++) begin : g_lane_chk
      assert_tail_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
         cand_valid[k] |-> ((cand_word[k*64 +: 64] >> {cand_len[k*LEN_W +: LEN_W], 3'b000}) == 64'd0));

      assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
         cand_valid[k] |-> (cand_len[k*LEN_W +: LEN_W] != '0 &&
                            cand_len[k*LEN_W +: LEN_W] <= LEN_W'(MAX_LEN)));
   end
endmodule

bind pwcand_gen pwcand_gen_chk #(
   .NUM_WORKERS(NUM_WORKERS),
   .MAX_LEN    (MAX_LEN),
   .LEN_W      (LEN_W)
) i_pwcand_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .cand_word (cand_word),
   .cand_len  (cand_len),
   .cand_valid(cand_valid),
   .busy      (busy),
   .found     (found),
   .exhausted (exhausted),
   .hit_word  (hit_word),
   .hit_len   (hit_len)
);

// File: tb/test_pwcand_gen.sv
`timescale 1ns/1ps
module test_pwcand_gen;
   localparam int NW  = 7;
   localparam int ML  = 2;
   localparam int LAT = 2;
   localparam int LW  = $clog2(ML + 1);

   localparam int M_IDLE = 0, M_RUN = 1, M_DRAIN = 2, M_FOUND = 3, M_EXH = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NW-1:0]     match = '0;
   logic [NW*64-1:0]  cand_word;
   logic [NW*LW-1:0]  cand_len;
   logic [NW-1:0]     cand_valid;
   logic              busy, found, exhausted;
   logic [63:0]       hit_word;
   logic [LW-1:0]     hit_len;

   pwcand_gen #(.NUM_WORKERS(NW), .MAX_LEN(ML), .MATCH_LATENCY(LAT)) i_pwcand_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .match(match),
      .cand_word(cand_word), .cand_len(cand_len), .cand_valid(cand_valid),
      .busy(busy), .found(found), .exhausted(exhausted),
      .hit_word(hit_word), .hit_len(hit_len));

   always #2.5 clk = ~clk;

   int          vecs = 0;
   int          bad  = 0;
   int          cyc  = 0;
   longint      total;
   int          m_st;
   longint      m_base;
   int          m_dcnt;
   logic [63:0] m_hw;
   int          m_hl;
   longint      hb[$];
   bit          hr[$];
   logic [NW-1:0] emu_q[$];
   logic [NW-1:0] raw_match = '0;
   bit          hit_last_drain = 1'b0;
   logic [63:0] tw_a, tw_b;
   int          tl_a = 0, tl_b = 0;

   // index -> string per R3: last character least significant
   function automatic void idx_to(input longint idx, output int len, output logic [63:0] w);
      longint rem = idx;
      longint span = 95;
      len = 1;
      w = '0;
      while (rem >= span) begin
         rem = rem - span;
         span = span * 95;
         len++;
      end
      for (int j = len - 1; j >= 0; j--) begin
         w[j*8 +: 8] = 8'(32 + (rem % 95));
         rem = rem / 95;
      end
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic set_tgt(input longint a, input longint b);
      if (a >= 0) idx_to(a, tl_a, tw_a); else tl_a = 0;
      if (b >= 0) idx_to(b, tl_b, tw_b); else tl_b = 0;
   endtask

   // reference model, updated at the active edge
   always @(posedge clk) begin
      longint eb;
      bit     er;
      int     win;
      if (!rst_n) begin
         m_st = M_IDLE; m_base = 0; m_dcnt = 0; m_hw = '0; m_hl = 0;
         hb.delete(); hr.delete();
      end else begin
         hb.push_front(m_base);
         hr.push_front(m_st == M_RUN);
         while (hb.size() > LAT + 1) begin
            void'(hb.pop_back());
            void'(hr.pop_back());
         end
         er = 1'b0; eb = 0;
         if (hr.size() == LAT + 1) begin er = hr[LAT]; eb = hb[LAT]; end
         win = -1;
         if (m_st == M_RUN || m_st == M_DRAIN)
            for (int k = NW - 1; k >= 0; k--)
               if (match[k] && er && (eb + k < total)) win = k;
         case (m_st)
            M_RUN, M_DRAIN: begin
               if (win >= 0) begin
                  m_st = M_FOUND;
                  idx_to(eb + win, m_hl, m_hw);
               end else if (m_st == M_RUN) begin
                  m_base = m_base + NW;
                  if (m_base >= total) begin
                     if (LAT == 0) m_st = M_EXH;
                     else begin m_st = M_DRAIN; m_dcnt = LAT; end
                  end
               end else if (m_dcnt == 1) m_st = M_EXH;
               else m_dcnt--;
            end
            default: if (start) begin
               m_st = M_RUN; m_base = 0; m_hw = '0; m_hl = 0;
               hb.delete(); hr.delete();
            end
         endcase
      end
   end

   // per-cycle compare and worker emulation, away from the edge
   always @(negedge clk) begin
      logic [NW-1:0] cur;
      logic [63:0]   ew;
      int            el;
      bit            ev;
      logic [7:0]    b;
      if (rst_n) begin
         for (int k = 0; k < NW; k++) begin
            ev = (m_st == M_RUN) && (m_base + k < total);
            chk(cand_valid[k] === ev, "R4 R5 lane valid", 64'(cand_valid[k]), 64'(ev));
            if (ev) begin
               idx_to(m_base + k, el, ew);
               chk(cand_word[k*64 +: 64] === ew, "R3 lane word", cand_word[k*64 +: 64], ew);
               chk(int'(cand_len[k*LW +: LW]) == el, "R3 lane len", 64'(cand_len[k*LW +: LW]), 64'(el));
            end
            if (cand_valid[k]) begin
               for (int j = 0; j < 8; j++) begin
                  b = cand_word[k*64 + j*8 +: 8];
                  if (j < int'(cand_len[k*LW +: LW]))
                     chk(b >= 8'd32 && b <= 8'd126, "R2 byte range", 64'(b), 64'd32);
                  else
                     chk(b == 8'd0, "R2 zero tail", 64'(b), 64'd0);
               end
            end
         end
         chk({busy, found, exhausted} === {(m_st == M_RUN || m_st == M_DRAIN), m_st == M_FOUND, m_st == M_EXH},
             "R6 R9 status", 64'({busy, found, exhausted}), 64'(m_st));
         chk(hit_word === m_hw && int'(hit_len) == m_hl, "R6 R7 hit", hit_word, m_hw);

         for (int k = 0; k < NW; k++)
            cur[k] = cand_valid[k] &&
                     ((tl_a != 0 && cand_word[k*64 +: 64] == tw_a && int'(cand_len[k*LW +: LW]) == tl_a) ||
                      (tl_b != 0 && cand_word[k*64 +: 64] == tw_b && int'(cand_len[k*LW +: LW]) == tl_b));
         emu_q.push_front(cur);
         while (emu_q.size() > LAT + 1) void'(emu_q.pop_back());
         match = (emu_q.size() == LAT + 1) ? emu_q[LAT] : '0;
         match = match | raw_match;
         if (hit_last_drain && m_st == M_DRAIN && m_dcnt == 1) match[NW-1] = 1'b1;
      end else begin
         emu_q.delete();
         match = '0;
      end
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (!(m_st == M_FOUND || m_st == M_EXH)) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] ew;
      int el;
      total = 0;
      begin
         longint span = 1;
         for (int l = 1; l <= ML; l++) begin span = span * 95; total = total + span; end
      end
      set_tgt(-1, -1);

      repeat (3) @(negedge clk);
      chk({busy, found, exhausted, cand_valid} == '0, "R1 reset flags", 64'({busy, found, exhausted}), 64'd0);
      chk(hit_word == '0 && hit_len == '0, "R1 reset hit", hit_word, 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({busy, found, exhausted, cand_valid} == '0, "R1 idle after reset", 64'(cand_valid), 64'd0);

      // single match in the middle of the sweep
      set_tgt(40, -1);
      pulse_start();
      chk(cand_word[63:0] == 64'h20 && cand_valid[0], "R4 first lane word", cand_word[63:0], 64'h20);
      wait_done();
      idx_to(40, el, ew);
      chk(found && hit_word == ew && int'(hit_len) == el, "R6 latched hit", hit_word, ew);

      // two lanes answer in one cycle; restart clears; start while busy ignored
      set_tgt(200, 198);
      pulse_start();
      chk(hit_word == '0 && !found && busy, "R10 restart clears", hit_word, 64'd0);
      repeat (3) @(negedge clk);
      pulse_start();
      idx_to(m_base, el, ew);
      chk(cand_word[63:0] == ew, "R10 busy start ignored", cand_word[63:0], ew);
      wait_done();
      idx_to(198, el, ew);
      chk(found && hit_word == ew, "R7 lowest lane wins", hit_word, ew);

      // matches while not busy are ignored
      raw_match = '1;
      repeat (3) @(negedge clk);
      raw_match = '0;
      @(negedge clk);
      chk(found && hit_word == ew, "R8 match after found ignored", hit_word, ew);

      // full sweep, forced match on the empty slot in the final drain cycle
      set_tgt(-1, -1);
      hit_last_drain = 1'b1;
      pulse_start();
      wait_done();
      hit_last_drain = 1'b0;
      chk(exhausted && !found, "R9 exhausted", 64'({found, exhausted}), 64'd1);
      chk(hit_word == '0 && hit_len == '0, "R8 invalid slot ignored", hit_word, 64'd0);

      // last candidate answers in the last drain cycle: found wins
      set_tgt(total - 1, -1);
      pulse_start();
      wait_done();
      idx_to(total - 1, el, ew);
      chk(found && !exhausted && hit_word == ew, "R9 match beats exhaustion", hit_word, ew);

      summary();
      $finish;
   end
endmodule